// File: doc/BRIEF.md
# Configurable SPI Master Port

This block is a single-byte SPI master with a register-style host side. The host writes a byte into the data buffer. That write starts an eight-bit full-duplex exchange on the serial pins, and no further host action is needed. The serial clock is derived from the system clock by a selectable ratio of 4, 16 or 64. Three settings shape the exchange: the idle level of the serial clock, the edge on which outgoing data changes, and the point at which incoming data is sampled. All three are taken from the configuration inputs at the moment of the buffer write.

When the last sample is taken, the received byte is placed in the buffer and a full flag is raised. A host read clears the flag. If the host writes the buffer while a byte is still being shifted, the write is refused. A sticky collision flag records the refusal until the host clears it with a dedicated strobe. The status byte gathers the full flag and the active configuration choices.

Top module: `spi_master_port`

## Requirements
- R1: After reset, `busy`, `wcol` and the full flag (`status[0]`) are 0, and `sclk` rests at the level of `cfg_cpol`.
- R2: A write (`wr_en`) while not busy starts a transfer. `busy` is 1 from the cycle after the write for exactly 8 × ratio system cycles, then returns to 0.
- R3: `cfg_ratio` selects the ratio: 0 gives 4, 1 gives 16, 2 or 3 gives 64. Each half of a bit period lasts ratio/2 system cycles.
- R4: When no transfer is active, `sclk` equals `cfg_cpol`. During a transfer with `cfg_cke`=1, the first half of each bit is at the idle level and the second half is at the active level. With `cfg_cke`=0, the first half is active and the second half is idle.
- R5: `mosi` carries the written byte most-significant bit first. Bit k is held for the whole of bit period k. `mosi` is 0 when idle.
- R6: With `cfg_smp_end`=0, `miso` is sampled at the end of the first half of each bit. With `cfg_smp_end`=1, it is sampled at the end of the second half. The first sampled bit becomes the most-significant bit of the received byte.
- R7: On the final sample, the received byte appears on `rd_data` and the full flag is set. `rd_en` clears the flag. If both happen in the same cycle, the set wins.
- R8: A write while `busy` is 1 sets `wcol` in the next cycle and leaves the ongoing transfer intact: the `mosi` bits, the `busy` duration and the received byte are unchanged.
- R9: `wcol` stays set until `clr_col` is strobed. If a collision and `clr_col` arrive in the same cycle, `wcol` ends up set.
- R10: `status[0]` is the full flag, `status[5:1]` read 0, `status[6]` reflects `cfg_cke` and `status[7]` reflects `cfg_smp_end`.
- R11: Configuration inputs are captured at the write that starts a transfer. Changing them during the transfer does not alter its `sclk`, `mosi` timing or sampling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ratio | input | 2 | Clock ratio select |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cke | input | 1 | Transmit edge select |
| cfg_smp_end | input | 1 | Sample at end (1) or middle (0) of bit |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | 8 | Byte to send |
| rd_en | input | 1 | Buffer read strobe (clears full flag) |
| rd_data | output | 8 | Last received byte |
| clr_col | input | 1 | Collision flag clear strobe |
| status | output | 8 | Status byte |
| busy | output | 1 | Transfer in progress |
| wcol | output | 1 | Sticky write-collision flag |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The write is taken at clock edge E0. With H = ratio/2, the following results fall due at fixed edges after E0:

- `busy`, `sclk` and `mosi` take their first transfer values after E0.
- Each half boundary falls at edge E0 + nH.
- The full flag and `rd_data` update after edge E0 + 15H for mid-bit sampling, or after E0 + 16H for end sampling.
- `busy` drops after E0 + 16H.
- `wcol` and flag clears show one edge after their strobe.

The bench counts edges from E0 and compares at every following falling edge, so each value is read half a cycle after the edge that produced it. `miso` is driven with a different pattern in each half of a bit, so the two sample points yield different expected bytes.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;

    localparam int DATA_W   = 8;
    localparam int HALF_MAX = 32;
    localparam int HCNT_W   = $clog2(HALF_MAX);
    localparam int BIT_W    = $clog2(DATA_W);

    typedef enum logic [1:0] {
        RATIO_4   = 2'd0,
        RATIO_16  = 2'd1,
        RATIO_64  = 2'd2,
        RATIO_64X = 2'd3
    } ratio_e;

    typedef struct packed {
        logic   cpol;
        logic   cke;
        logic   smp_end;
        ratio_e ratio;
    } link_cfg_t;

    // last count value of one half bit period (half length minus one)
    function automatic logic [HCNT_W-1:0] half_limit(ratio_e r);
        case (r)
            RATIO_4:  return HCNT_W'(1);
            RATIO_16: return HCNT_W'(7);
            default:  return HCNT_W'(HALF_MAX - 1);
        endcase
    endfunction

    // serial clock level for a given half of a bit
    function automatic logic sclk_level(link_cfg_t c, logic half);
        return c.cpol ^ (half == c.cke);
    endfunction

endpackage

// File: rtl/spi_half_timer.sv
`timescale 1ns/1ps
module spi_half_timer #(
    parameter int HCNT_W = spi_port_pkg::HCNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [HCNT_W-1:0] limit,
    output logic              half_end
);
    logic [HCNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (cnt_q == limit)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + HCNT_W'(1);
    end

    assign half_end = run && (cnt_q == limit);
endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine #(
    parameter int DATA_W = spi_port_pkg::DATA_W,
    parameter int BIT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] start_data,
    input  logic              half_end,
    input  logic              smp_end,
    input  logic              miso,
    output logic              busy,
    output logic              half,
    output logic              mosi,
    output logic              samp_last,
    output logic [DATA_W-1:0] rx_word
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    logic              busy_q;
    logic              half_q;
    logic [BIT_W-1:0]  bitn_q;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-2:0] rx_q;
    logic              samp;

    assign samp = busy_q && half_end && (half_q == smp_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            half_q <= 1'b0;
            bitn_q <= '0;
            tx_q   <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            half_q <= 1'b0;
            bitn_q <= '0;
            tx_q   <= start_data;
        end else if (busy_q && half_end) begin
            half_q <= ~half_q;
            if (half_q) begin
                tx_q   <= tx_q << 1;
                bitn_q <= bitn_q + BIT_W'(1);
                if (bitn_q == LAST_BIT)
                    busy_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rx_q <= '0;
        else if (samp)
            rx_q <= {rx_q[DATA_W-3:0], miso};
    end

    assign busy      = busy_q;
    assign half      = half_q;
    assign mosi      = busy_q & tx_q[DATA_W-1];
    assign samp_last = samp && (bitn_q == LAST_BIT);
    assign rx_word   = {rx_q, miso};
endmodule

// File: rtl/spi_flags.sv
`timescale 1ns/1ps
module spi_flags #(
    parameter int DATA_W = spi_port_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              rd,
    input  logic              col_set,
    input  logic              col_clr,
    output logic              full,
    output logic              wcol,
    output logic [DATA_W-1:0] rbuf
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            wcol <= 1'b0;
            rbuf <= '0;
        end else begin
            if (load) begin
                full <= 1'b1;
                rbuf <= load_data;
            end else if (rd) begin
                full <= 1'b0;
            end
            if (col_set)
                wcol <= 1'b1;
            else if (col_clr)
                wcol <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_master_port.sv
`timescale 1ns/1ps
module spi_master_port
    import spi_port_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int STS_W = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    cfg_ratio,
    input  logic          cfg_cpol,
    input  logic          cfg_cke,
    input  logic          cfg_smp_end,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          clr_col,
    output logic [STS_W-1:0] status,
    output logic          busy,
    output logic          wcol,
    output logic          sclk,
    output logic          mosi,
    input  logic          miso
);
    link_cfg_t cfg_in, cfg_q;
    logic      start, collide, half_end, half, samp_last, full;
    logic [DW-1:0] rx_word;

    assign cfg_in  = '{cpol: cfg_cpol, cke: cfg_cke, smp_end: cfg_smp_end,
                       ratio: ratio_e'(cfg_ratio)};
    assign start   = wr_en & ~busy;
    assign collide = wr_en & busy;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '{cpol: 1'b0, cke: 1'b0, smp_end: 1'b0, ratio: RATIO_4};
        else if (start)
            cfg_q <= cfg_in;
    end

    spi_half_timer #(.HCNT_W(HCNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .limit    (half_limit(cfg_q.ratio)),
        .half_end (half_end)
    );

    spi_shift_engine #(.DATA_W(DW)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_data (wr_data),
        .half_end   (half_end),
        .smp_end    (cfg_q.smp_end),
        .miso       (miso),
        .busy       (busy),
        .half       (half),
        .mosi       (mosi),
        .samp_last  (samp_last),
        .rx_word    (rx_word)
    );

    spi_flags #(.DATA_W(DW)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .load      (samp_last),
        .load_data (rx_word),
        .rd        (rd_en),
        .col_set   (collide),
        .col_clr   (clr_col),
        .full      (full),
        .wcol      (wcol),
        .rbuf      (rd_data)
    );

    assign sclk = busy ? sclk_level(cfg_q, half) : cfg_cpol;

    always_comb begin
        status    = '0;
        status[0] = full;
        status[6] = cfg_cke;
        status[7] = cfg_smp_end;
    end
endmodule

// File: rtl/spi_master_port_chk.sv
`timescale 1ns/1ps
module spi_master_port_chk (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic rd_en,
    input logic clr_col,
    input logic busy,
    input logic wcol,
    input logic full
);
    // R1: reset leaves the port idle with both flags clear
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!busy && !wcol && !full));

    // R2: an accepted write makes the port busy on the next cycle
    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy) |=> busy);

    // R8: a write during a transfer raises the collision flag
    a_r8_collision_set: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy) |=> wcol);

    // R9: the collision flag only falls after a clear strobe
    a_r9_col_sticky: assert property (@(posedge clk) disable iff (rst)
        (wcol && !clr_col) |=> wcol);

    // R7: the full flag only falls after a read
    a_r7_full_hold: assert property (@(posedge clk) disable iff (rst)
        (full && !rd_en) |=> full);
endmodule

bind spi_master_port spi_master_port_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .clr_col (clr_col),
    .busy    (busy),
    .wcol    (wcol),
    .full    (status[0])
);

// File: tb/spi_master_port_tb.sv
`timescale 1ns/1ps
module spi_master_port_tb;
    localparam int NONE = -100;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] cfg_ratio;
    logic       cfg_cpol, cfg_cke, cfg_smp_end;
    logic       wr_en, rd_en, clr_col, miso;
    logic [7:0] wr_data, rd_data, status;
    logic       busy, wcol, sclk, mosi;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  exp_full = 1'b0;
    bit  exp_col  = 1'b0;

    always #10 clk = ~clk;

    spi_master_port u_dut (
        .clk(clk), .rst(rst), .cfg_ratio(cfg_ratio), .cfg_cpol(cfg_cpol),
        .cfg_cke(cfg_cke), .cfg_smp_end(cfg_smp_end), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .clr_col(clr_col), .status(status), .busy(busy), .wcol(wcol),
        .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int half_len(input logic [1:0] r);
        case (r)
            2'd0:    return 2;
            2'd1:    return 8;
            default: return 32;
        endcase
    endfunction

    task automatic status_chk();
        chk(status[0] == exp_full, "R7/R10 status[0] full", status[0], exp_full);
        chk(status[5:1] == 5'd0, "R10 status[5:1] zero", status[5:1], 0);
        chk(status[6] == cfg_cke && status[7] == cfg_smp_end, "R10 status[7:6] cfg",
            status[7:6], {cfg_smp_end, cfg_cke});
    endtask

    // one transfer; t counts edges since the write edge E0
    task automatic xfer(input logic [1:0] rs, input logic cp, input logic ck, input logic sm,
                        input logic [7:0] txb, input logic [7:0] pa, input logic [7:0] pb,
                        input int coll_t, input int clr_t, input int rd_t,
                        input int chg_t, input bit rd_end);
        int h_len = half_len(rs);
        int last_s = sm ? 16 * h_len : 15 * h_len;
        logic [7:0] exp_rx = sm ? pb : pa;
        @(negedge clk);
        cfg_ratio = rs; cfg_cpol = cp; cfg_cke = ck; cfg_smp_end = sm;
        wr_en = 1'b1; wr_data = txb; rd_en = 1'b0; clr_col = 1'b0;
        @(posedge clk);
        for (int t = 0; t <= 16 * h_len; t++) begin
            int k = t / (2 * h_len);
            int hh = (t / h_len) % 2;
            @(negedge clk);
            wr_en = 1'b0; rd_en = 1'b0; clr_col = 1'b0;
            if (t == clr_t + 1) exp_col = 1'b0;
            if (t == coll_t + 1) exp_col = 1'b1;
            if (t == rd_t + 1) exp_full = 1'b0;
            if (t >= last_s) exp_full = 1'b1;
            chk(wcol == exp_col, "R8/R9 wcol", wcol, exp_col);
            chk(status[0] == exp_full, "R7 full flag", status[0], exp_full);
            if (t < 16 * h_len) begin
                chk(busy == 1'b1, "R2/R3 busy during transfer", busy, 1);
                chk(sclk == (cp ^ (hh[0] == ck)), "R4/R11 sclk level", sclk, cp ^ (hh[0] == ck));
                chk(mosi == txb[7-k], "R5/R8 mosi bit", mosi, txb[7-k]);
                miso = hh[0] ? pb[7-k] : pa[7-k];
                if (t == coll_t) begin wr_en = 1'b1; wr_data = ~txb; end
                if (t == clr_t) clr_col = 1'b1;
                if (t == rd_t) rd_en = 1'b1;
                if (t == chg_t) begin
                    cfg_cpol = ~cfg_cpol; cfg_cke = ~cfg_cke;
                    cfg_smp_end = ~cfg_smp_end; cfg_ratio = cfg_ratio ^ 2'd1;
                end
            end else begin
                chk(busy == 1'b0, "R2 busy ends after 8*ratio", busy, 0);
                chk(sclk == cfg_cpol, "R4 sclk idle", sclk, cfg_cpol);
                chk(mosi == 1'b0, "R5 mosi idle", mosi, 0);
                chk(rd_data == exp_rx, "R6/R7/R8/R11 received byte", rd_data, exp_rx);
                status_chk();
            end
        end
        if (rd_end) begin
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
            exp_full = 1'b0;
            chk(status[0] == 1'b0, "R7 read clears full", status[0], 0);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        rst = 1'b1; cfg_ratio = 2'd0; cfg_cpol = 1'b1; cfg_cke = 1'b0; cfg_smp_end = 1'b0;
        wr_en = 1'b0; wr_data = 8'h00; rd_en = 1'b0; clr_col = 1'b0; miso = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(wcol == 1'b0, "R1 wcol after reset", wcol, 0);
        chk(status[0] == 1'b0, "R1 full after reset", status[0], 0);
        chk(sclk == 1'b1, "R1 sclk idle high", sclk, 1);
        cfg_cpol = 1'b0;
        @(negedge clk);
        chk(sclk == 1'b0, "R1/R4 sclk idle low", sclk, 0);

        // directed: all four clock modes, three ratios (R3, R4, R6)
        xfer(2'd0, 1'b0, 1'b1, 1'b0, 8'hA5, 8'h3C, 8'hC3, NONE, NONE, NONE, NONE, 1'b1);
        xfer(2'd1, 1'b1, 1'b0, 1'b1, 8'h5A, 8'h0F, 8'hF0, NONE, NONE, NONE, NONE, 1'b1);
        xfer(2'd2, 1'b1, 1'b1, 1'b0, 8'h81, 8'h96, 8'h69, NONE, NONE, NONE, NONE, 1'b0);
        xfer(2'd3, 1'b0, 1'b0, 1'b1, 8'h7E, 8'h55, 8'hAA, NONE, NONE, NONE, NONE, 1'b1);
        // R8: collision mid transfer, then on the very last busy cycle
        xfer(2'd0, 1'b0, 1'b0, 1'b0, 8'hC6, 8'h12, 8'h34, 5, NONE, NONE, NONE, 1'b0);
        // R9: clear strobe clears the flag
        xfer(2'd0, 1'b1, 1'b1, 1'b1, 8'h39, 8'hE1, 8'h1E, NONE, 3, NONE, NONE, 1'b1);
        xfer(2'd1, 1'b1, 1'b1, 1'b1, 8'hF0, 8'hAB, 8'hCD, 16*8-1, NONE, NONE, NONE, 1'b1);
        // R9: collision and clear in the same cycle -> stays set
        xfer(2'd0, 1'b0, 1'b1, 1'b0, 8'h01, 8'hFF, 8'h00, 7, 7, NONE, NONE, 1'b1);
        xfer(2'd0, 1'b0, 1'b1, 1'b0, 8'h02, 8'h00, 8'hFF, NONE, 2, NONE, NONE, 1'b1);
        // R7: read on the final sampling edge, set wins (mid and end sampling)
        xfer(2'd0, 1'b0, 1'b1, 1'b0, 8'h44, 8'h9C, 8'h63, NONE, NONE, 15*2-1, NONE, 1'b0);
        xfer(2'd1, 1'b0, 1'b1, 1'b1, 8'h88, 8'h9C, 8'h63, NONE, NONE, 16*8-1, NONE, 1'b1);
        // R11: configuration flipped mid transfer has no effect
        xfer(2'd1, 1'b0, 1'b1, 1'b0, 8'hB7, 8'h4D, 8'hB2, NONE, NONE, NONE, 9, 1'b1);

        // random mix
        for (int i = 0; i < 24; i++) begin
            logic [1:0] rs = 2'($urandom_range(0, 3));
            int hl = half_len(rs);
            int ct = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 16 * hl - 1)) : NONE;
            int cl = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 16 * hl - 1)) : NONE;
            xfer(rs, 1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
                 8'($urandom), 8'($urandom), ct, cl, NONE, NONE, 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule